// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM Datapath

This block is a small synthesizable synchronous SRAM. Address, chip enables, write controls and write data are captured on the rising clock edge. The data bus is split into byte lanes. A write either stores every lane (global write) or only the lanes whose select lines are active (byte write).

Read data leaves the block on one of two paths, chosen by a static strap:
- **Flow-through:** the word goes out straight from the array. It is valid in the cycle after the read is captured.
- **Pipelined:** the word first passes through an output register and appears one cycle later.

The output drive-enable is gated by an asynchronous active-low output enable and by an asynchronous sleep input. Sleep also makes the block ignore the commands it samples, and the array keeps its contents through sleep.

Deselect uses a single-cycle rule. A deselect captured on an edge turns the drive off right after that edge, in both read modes. Burst address generation is not part of this block; a separate counter supplies the addresses.

Top module: `ssram_datapath`

## Requirements
- R1: The device is selected only when `ce_a_n` is 0, `ce_b` is 1 and `ce_c_n` is 0 at the capturing edge. Any other combination performs no write and schedules no read.
- R2: With `pipe_mode` = 0, a read captured at edge k drives `dq_out` with the addressed word during the cycle after edge k, with `dq_oe` = 1.
- R3: With `pipe_mode` = 1, a read captured at edge k drives the word during the cycle after edge k+1. The word is the content as it stood when the read was captured, even if a write to the same address is captured at edge k+1.
- R4: With `glb_wr_n` = 0 on a selected cycle, all byte lanes are written from `dq_in`, whatever `byte_wr_n` and `lane_n` are.
- R5: With `glb_wr_n` = 1, `byte_wr_n` = 0 and `lane_n[i]` = 0, lane i (bits 8i+7..8i) is written. Lanes whose `lane_n` bit is 1 keep their old value.
- R6: A selected cycle with `byte_wr_n` = 0, every `lane_n` bit 1 and `glb_wr_n` = 1 is a read, not a write.
- R7: A deselect captured at edge e forces `dq_oe` to 0 in the cycle after e, in both modes. In pipelined mode this includes a read captured at edge e-1.
- R8: `oe_n` = 1 forces `dq_oe` to 0 at once, without a clock. A pending read drives again as soon as `oe_n` returns to 0.
- R9: `sleep` = 1 forces `dq_oe` to 0 at once. Commands sampled while `sleep` is 1 are ignored, and the array contents are kept.
- R10: Synchronous reset clears every pending read, so `dq_oe` is 0 after reset.
- R11: A write command never schedules read data. In flow-through mode, `dq_oe` is 0 in the cycle after a write is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | Read-path strap: 0 flow-through, 1 pipelined |
| addr | input | AW | Word address |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| glb_wr_n | input | 1 | Global write, active low, overrides byte write |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| lane_n | input | NB | Per-lane write selects, active low |
| dq_in | input | NB*8 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power request, active high |
| dq_out | output | NB*8 | Read data |
| dq_oe | output | 1 | Drive-enable for `dq_out` |

## Verification
The hardest situation to reach is a pipelined read whose data window is cut by a deselect captured on the very next edge. It needs a read and a deselect on adjacent edges after a mode-strap reset. The bench issues exactly that pair, and it also issues a read followed at once by a write to the same address, to show that the output register holds the old word.

The asynchronous gates need a second kind of stimulus. `oe_n` and `sleep` are toggled while repeated reads keep a read pending, and each change is sampled within the same clock period. Writes issued during sleep are later read back to confirm that they were dropped.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
    localparam int unsigned DEF_AW = 6;
    localparam int unsigned DEF_NB = 4;
    localparam int unsigned LANE_W = 8;

    typedef enum logic {
        MODE_FLOW = 1'b0,
        MODE_PIPE = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
    } ctl_t;

    function automatic ctl_t decode_ctl(
        input logic ce_a_n,
        input logic ce_b,
        input logic ce_c_n,
        input logic asleep,
        input logic glb_n,
        input logic byte_n,
        input logic any_lane
    );
        ctl_t c;
        c.sel = !ce_a_n && ce_b && !ce_c_n && !asleep;
        c.wr  = c.sel && (!glb_n || (!byte_n && any_lane));
        c.rd  = c.sel && !c.wr;
        return c;
    endfunction
endpackage

// File: rtl/ssram_cmd_reg.sv
module ssram_cmd_reg
    import ssram_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int NB = DEF_NB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_a_n,
    input  logic          ce_b,
    input  logic          ce_c_n,
    input  logic          glb_wr_n,
    input  logic          byte_wr_n,
    input  logic          sleep,
    input  logic [NB-1:0] lane_n,
    input  logic [AW-1:0] addr,
    output ctl_t          now_ctl,
    output logic [NB-1:0] wr_lanes,
    output logic          rd_q,
    output logic [AW-1:0] addr_q
);
    logic any_lane;
    logic ce_ok;

    assign any_lane = |(~lane_n);
    assign ce_ok    = !ce_a_n && ce_b && !ce_c_n;

    always_comb begin
        now_ctl = decode_ctl(ce_a_n, ce_b, ce_c_n, sleep, glb_wr_n, byte_wr_n, any_lane);
    end

    always_comb begin
        if (!now_ctl.wr)      wr_lanes = '0;
        else if (!glb_wr_n)   wr_lanes = '1;
        else                  wr_lanes = ~lane_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            rd_q   <= now_ctl.rd;
            addr_q <= addr;
        end
    end

    assert_ce_gate_R1: assert property (@(posedge clk) disable iff (rst)
        !ce_ok |-> (wr_lanes == '0 && !now_ctl.rd));

    assert_glb_all_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        (ce_ok && !sleep && !glb_wr_n) |-> (&wr_lanes));

    assert_byte_only_sel_R5: assert property (@(posedge clk) disable iff (rst)
        (ce_ok && !sleep && glb_wr_n && !byte_wr_n) |-> ((wr_lanes & lane_n) == '0));

    assert_empty_byte_is_read_R6: assert property (@(posedge clk) disable iff (rst)
        (ce_ok && !sleep && glb_wr_n && !byte_wr_n && (&lane_n)) |-> (now_ctl.rd && wr_lanes == '0));

    assert_sleep_ignores_R9: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (wr_lanes == '0 && !now_ctl.rd));
endmodule

// File: rtl/ssram_array.sv
module ssram_array
    import ssram_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int NB = DEF_NB,
    parameter int LW = LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NB-1:0]    we_lanes,
    input  logic [AW-1:0]    waddr,
    input  logic [NB*LW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NB*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LW-1:0] mem_l [DEPTH];

        always_ff @(posedge clk) begin
            if (we_lanes[g]) mem_l[waddr] <= wdata[g*LW +: LW];
        end

        assign rdata[g*LW +: LW] = mem_l[raddr];

        assert_lane_stored_R5: assert property (@(posedge clk) disable iff (rst)
            we_lanes[g] |=> (mem_l[$past(waddr)] == $past(wdata[g*LW +: LW])));
    end
endmodule

// File: rtl/ssram_out_path.sv
module ssram_out_path
    import ssram_pkg::*;
#(
    parameter int DW = DEF_NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  rd_mode_e      mode,
    input  logic          rd_q,
    input  logic          sel_now,
    input  logic [DW-1:0] arr_rdata,
    input  logic          oe_n,
    input  logic          sleep,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    logic          s2_rd;
    logic [DW-1:0] s2_data;
    logic          pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_rd   <= 1'b0;
            s2_data <= '0;
        end else begin
            s2_rd   <= rd_q && sel_now;
            s2_data <= arr_rdata;
        end
    end

    assign pending = (mode == MODE_PIPE) ? s2_rd : rd_q;
    assign dq_oe   = pending && !oe_n && !sleep;
    assign dq_out  = (mode == MODE_PIPE) ? s2_data : arr_rdata;

    assert_scd_off_R7: assert property (@(posedge clk) disable iff (rst)
        !sel_now |=> (!dq_oe || $fell(sleep) || $fell(oe_n) ? !pending : 1'b1));

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);

    assert_sleep_gate_R9: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dq_oe);

    assert_pipe_source_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PIPE && $stable(mode) && dq_oe) |-> $past(rd_q));
endmodule

// File: rtl/ssram_datapath.sv
module ssram_datapath
    import ssram_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int NB = DEF_NB,
    localparam int DW = NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pipe_mode,
    input  logic [AW-1:0] addr,
    input  logic          ce_a_n,
    input  logic          ce_b,
    input  logic          ce_c_n,
    input  logic          glb_wr_n,
    input  logic          byte_wr_n,
    input  logic [NB-1:0] lane_n,
    input  logic [DW-1:0] dq_in,
    input  logic          oe_n,
    input  logic          sleep,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    ctl_t          now_ctl;
    logic [NB-1:0] wr_lanes;
    logic          rd_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] arr_rdata;
    rd_mode_e      mode;

    assign mode = rd_mode_e'(pipe_mode);

    ssram_cmd_reg #(.AW(AW), .NB(NB)) cmd_i (
        .clk(clk), .rst(rst),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .glb_wr_n(glb_wr_n), .byte_wr_n(byte_wr_n), .sleep(sleep),
        .lane_n(lane_n), .addr(addr),
        .now_ctl(now_ctl), .wr_lanes(wr_lanes),
        .rd_q(rd_q), .addr_q(addr_q)
    );

    ssram_array #(.AW(AW), .NB(NB), .LW(LANE_W)) array_i (
        .clk(clk), .rst(rst),
        .we_lanes(wr_lanes), .waddr(addr), .wdata(dq_in),
        .raddr(addr_q), .rdata(arr_rdata)
    );

    ssram_out_path #(.DW(DW)) out_i (
        .clk(clk), .rst(rst), .mode(mode),
        .rd_q(rd_q), .sel_now(now_ctl.sel),
        .arr_rdata(arr_rdata), .oe_n(oe_n), .sleep(sleep),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    assert_write_no_drive_R11: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && $stable(pipe_mode) && now_ctl.wr) |=> !dq_oe);

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> !dq_oe);
endmodule

// File: tb/ssram_datapath_tb.sv
module ssram_datapath_tb_top;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = NB * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pipe_mode = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
    logic          glb_wr_n = 1'b1, byte_wr_n = 1'b1;
    logic [NB-1:0] lane_n = '1;
    logic [DW-1:0] dq_in = '0;
    logic          oe_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    ssram_datapath #(.AW(AW), .NB(NB)) dut_i (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .addr(addr),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .glb_wr_n(glb_wr_n), .byte_wr_n(byte_wr_n), .lane_n(lane_n),
        .dq_in(dq_in), .oe_n(oe_n), .sleep(sleep),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Behavioural reference: a word array plus the two read latencies as flags.
    logic [DW-1:0] ref_mem [64];
    bit            m_rd1 = 0, m_rd2 = 0;
    int            m_addr1 = 0;
    logic [DW-1:0] m_data2 = '0;

    always @(posedge clk) begin
        bit sel, wr;
        if (rst) begin
            m_rd1 = 0;
            m_rd2 = 0;
        end else begin
            sel = (ce_a_n == 0) && (ce_b == 1) && (ce_c_n == 0) && (sleep == 0);
            wr  = sel && (glb_wr_n == 0 || (byte_wr_n == 0 && lane_n != 4'hF));
            m_rd2   = m_rd1 && sel;
            m_data2 = ref_mem[m_addr1];
            if (wr) begin
                for (int i = 0; i < NB; i++)
                    if (glb_wr_n == 0 || lane_n[i] == 0)
                        ref_mem[addr][i*8 +: 8] = dq_in[i*8 +: 8];
            end
            m_rd1   = sel && !wr;
            m_addr1 = int'(addr);
        end
    end

    always @(negedge clk) begin
        bit            exp_oe;
        logic [DW-1:0] exp_d;
        #5;
        if (!done) begin
            exp_oe = (pipe_mode ? m_rd2 : m_rd1) && !oe_n && !sleep;
            exp_d  = pipe_mode ? m_data2 : ref_mem[m_addr1];
            n_chk++;
            if (dq_oe !== exp_oe) begin
                n_fail++;
                $display("FAIL %s: dq_oe actual %b expected %b at %0t", cur_req, dq_oe, exp_oe, $time);
            end else if (exp_oe && dq_out !== exp_d) begin
                n_fail++;
                $display("FAIL %s: dq_out actual %h expected %h at %0t", cur_req, dq_out, exp_d, $time);
            end
        end
    end

    task automatic cyc(input logic [2:0] ce, input logic g, input logic b,
                       input logic [3:0] ln, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        {ce_a_n, ce_b, ce_c_n} = ce;
        glb_wr_n = g; byte_wr_n = b; lane_n = ln;
        addr = AW'(a); dq_in = d;
    endtask

    task automatic wr_all(input int a, input logic [DW-1:0] d);
        cyc(3'b010, 1'b0, 1'b1, 4'b1010, a, d);
    endtask
    task automatic rd(input int a);
        cyc(3'b010, 1'b1, 1'b1, 4'hF, a, '0);
    endtask
    task automatic idle();
        cyc(3'b101, 1'b1, 1'b1, 4'hF, 0, '0);
    endtask

    task automatic do_reset(input logic pm);
        @(negedge clk);
        rst = 1'b1; pipe_mode = pm;
        idle(); idle();
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return 32'hA500_0000 ^ (32'(a) * 32'h0103_0507);
    endfunction

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R10: reset state
        do_reset(1'b0);
        cur_req = "R10";
        idle();
        @(negedge clk); #6;
        n_chk++;
        if (dq_oe !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: dq_oe actual %b expected 0", dq_oe);
        end

        // R4: global write ignores lane selects
        cur_req = "R4";
        for (int a = 0; a < 8; a++) wr_all(a, pat(a));
        // R2: flow-through reads
        cur_req = "R2";
        for (int a = 0; a < 8; a++) rd(a);
        rd(7); rd(0);
        // R5: byte write to lanes 0 and 2
        cur_req = "R5";
        cyc(3'b010, 1'b1, 1'b0, 4'b1010, 3, 32'h1122_3344);
        rd(3);
        cyc(3'b010, 1'b1, 1'b0, 4'b0111, 4, 32'hDEAD_BEEF);
        rd(4);
        // R6: byte enable with no lane selected is a read
        cur_req = "R6";
        cyc(3'b010, 1'b1, 1'b0, 4'hF, 5, 32'hFFFF_FFFF);
        rd(5);
        // R1: each enable off alone, with a global write attempt
        cur_req = "R1";
        cyc(3'b110, 1'b0, 1'b1, 4'h0, 6, 32'h0);
        cyc(3'b000, 1'b0, 1'b1, 4'h0, 6, 32'h0);
        cyc(3'b011, 1'b0, 1'b1, 4'h0, 6, 32'h0);
        cyc(3'b000, 1'b1, 1'b1, 4'hF, 6, 32'h0);
        rd(6);
        // R11: write never schedules read data
        cur_req = "R11";
        wr_all(9, 32'h0BAD_F00D);
        wr_all(10, 32'h600D_CAFE);
        rd(9); rd(10);
        // R7: read then deselect
        cur_req = "R7";
        rd(2); idle(); rd(1); idle(); idle();
        // R8: async output enable during a pending read
        cur_req = "R8";
        rd(3);
        rd(3); #3 oe_n = 1'b1;
        rd(3); #3 oe_n = 1'b0;
        rd(3);
        // R9: sleep blocks commands, keeps contents
        cur_req = "R9";
        rd(4);
        @(negedge clk); #3 sleep = 1'b1;
        wr_all(2, 32'h0);
        rd(2);
        cyc(3'b010, 1'b1, 1'b0, 4'h0, 1, 32'h0);
        @(negedge clk); sleep = 1'b0;
        rd(2); rd(1); idle();

        // Pipelined mode
        do_reset(1'b1);
        cur_req = "R3";
        for (int a = 0; a < 8; a++) rd(a);
        idle();
        rd(3); wr_all(3, 32'h5555_AAAA); rd(3); idle(); idle();
        cur_req = "R7";
        rd(4); idle(); idle();
        rd(5); rd(6); idle(); idle();
        cur_req = "R8";
        rd(0); rd(0); #3 oe_n = 1'b1;
        rd(0); #3 oe_n = 1'b0;
        idle(); idle();
        cur_req = "R9";
        rd(7); #3 sleep = 1'b1;
        wr_all(7, 32'h0);
        @(negedge clk); sleep = 1'b0;
        rd(7); idle(); idle();
        cur_req = "R11";
        wr_all(11, 32'h1234_5678); idle(); rd(11); idle(); idle();

        @(negedge clk);
        @(negedge clk);
        #8;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule